// File: doc/BRIEF.md
# Overlapped Serial ADC Host Sequencer

This block is the host-side master for a 12-bit serial converter that runs from a clock the host supplies. It drives the active-low chip select, a divided serial clock and the serial command line. It reads the converter's data line in the same frame. Each command taken on a valid/ready port becomes an 8-bit control word, sent MSB first and led by a start bit. The 12-bit answer of that conversion is shifted back while the following control word is already going out.

The two schedules are set by `cfg_ovl` when a run begins. The overlapped schedule starts a new conversion every 15 serial clocks. The plain schedule starts one every 16. Chip select stays low for as long as commands keep arriving in their slots. When no command is waiting at a slot, the block sends zero-valued padding clocks until the last answer is in, and then releases chip select. Each answer is presented for one cycle with the channel that asked for it.

Top module: `adc_host_seq`

## Requirements
- R1: After reset, and between runs, `cs_n` is 1, `sclk` is 0, `mosi` is 0, `res_valid` is 0 and `cmd_ready` is 1.
- R2: While `cs_n` is low, each serial clock period is 2*HALF_DIV system clocks and begins with its low half. `mosi` changes only when `sclk` falls or when `cs_n` falls. `miso` is sampled as `sclk` rises.
- R3: The control word is sent MSB first. Bit 7 is a start bit of 1, bits 6:4 carry `cmd_chan` and bits 3:0 carry `cmd_opt`.
- R4: With `cfg_ovl`=1 at the start of a run, start bits are sampled on serial clocks 0, 15, 30 and so on, counted by rising edges from the first one after `cs_n` falls.
- R5: With `cfg_ovl`=0 at the start of a run, start bits fall on serial clocks 0, 16, 32 and so on.
- R6: Changing `cfg_ovl` while `cs_n` is low has no effect on the spacing of the run already in progress.
- R7: The answer bits of a conversion are sampled on rises 9 to 20 after that conversion's start-bit rise, MSB first. They appear as a one-cycle `res_valid` pulse with `res_data`, and `res_chan` equals the requested channel.
- R8: A command is taken when the block is idle, or at the falling edge that closes the last clock of a frame. With `cmd_valid` held high, all conversions of a run share one low period of `cs_n`.
- R9: When no command is present at a slot, `mosi` stays 0 and the run ends after rise 20 of the last conversion. A run of N conversions with period P therefore has (N-1)*P+21 rising edges.
- R10: Each accepted command yields exactly one result, and results come back in command order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ovl | input | 1 | 1 selects 15-clock overlapped spacing, 0 selects 16-clock spacing; taken at run start |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when valid is also high |
| cmd_chan | input | 3 | Channel of the command |
| cmd_opt | input | 4 | Option bits placed in the low nibble of the control word |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock to the converter |
| mosi | output | 1 | Serial control word to the converter |
| miso | input | 1 | Serial answer from the converter |
| res_valid | output | 1 | One-cycle answer strobe |
| res_data | output | 12 | Captured answer |
| res_chan | output | 3 | Channel of the captured answer |

## Verification
The assertions assume that the converter changes `miso` only after `sclk` falls. They also assume that `cfg_ovl` matters only while the block is idle. The bench's converter model drives each answer bit on the falling edge before the rise that samples it, so `miso` is stable at every sampling point. Commands are driven on the falling system-clock edge and held until accepted. The model decodes every control word it receives and derives its answer from the decoded channel. A wrongly sent word therefore shows up both in the word check and in the answer check.

// File: rtl/adc_host_pkg.sv
`timescale 1ns/1ps
package adc_host_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} seq_state_e;
endpackage

// File: rtl/ahs_sclk_div.sv
`timescale 1ns/1ps
module ahs_sclk_div #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int HC_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [HC_W-1:0] hcnt;
  logic            wrap;

  assign wrap     = run && (hcnt == HC_W'(HALF_DIV - 1));
  assign rise_stb = wrap && !sclk;
  assign fall_stb = wrap && sclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      hcnt <= '0;
      sclk <= 1'b0;
    end else if (wrap) begin
      hcnt <= '0;
      sclk <= ~sclk;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end
endmodule

// File: rtl/ahs_tx_shift.sv
`timescale 1ns/1ps
module ahs_tx_shift #(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CTRL_W-1:0] load_word,
  input  logic              shift,
  output logic              mosi
);
  logic [CTRL_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      mosi <= 1'b0;
    end else if (load) begin
      mosi <= load_word[CTRL_W-1];
      sreg <= {load_word[CTRL_W-2:0], 1'b0};
    end else if (shift) begin
      mosi <= sreg[CTRL_W-1];
      sreg <= {sreg[CTRL_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/ahs_rx_capture.sv
`timescale 1ns/1ps
module ahs_rx_capture #(
  parameter int RES_W = 12,
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample,
  input  logic             first,
  input  logic             miso,
  input  logic [TAG_W-1:0] tag_in,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data,
  output logic [TAG_W-1:0] res_tag
);
  localparam int LC_W = $clog2(RES_W);

  logic [RES_W-1:0] sh;
  logic [LC_W-1:0]  left;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      left      <= '0;
      tag_q     <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_tag   <= '0;
    end else begin
      res_valid <= 1'b0;
      if (sample && first) begin
        sh    <= {{(RES_W-1){1'b0}}, miso};
        left  <= LC_W'(RES_W - 1);
        tag_q <= tag_in;
      end else if (sample && left != '0) begin
        sh   <= {sh[RES_W-2:0], miso};
        left <= left - 1'b1;
        if (left == LC_W'(1)) begin
          res_valid <= 1'b1;
          res_data  <= {sh[RES_W-2:0], miso};
          res_tag   <= tag_q;
        end
      end
    end
  end

  // R7: the strobe lasts one cycle and follows a sampling edge
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  a_r7_after_sample: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(sample));
endmodule

// File: rtl/adc_host_seq.sv
`timescale 1ns/1ps
module adc_host_seq
  import adc_host_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int CHAN_W   = 3,
  parameter int OPT_W    = 4,
  parameter int RES_W    = 12,
  parameter int PER_OVL  = 15,
  parameter int PER_SEQ  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_ovl,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CHAN_W-1:0] cmd_chan,
  input  logic [OPT_W-1:0]  cmd_opt,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              res_valid,
  output logic [RES_W-1:0]  res_data,
  output logic [CHAN_W-1:0] res_chan
);
  localparam int CTRL_W    = 1 + CHAN_W + OPT_W;
  localparam int RES_FIRST = CTRL_W + 1;
  localparam int FRAME_END = RES_FIRST + RES_W;
  localparam int CNT_W     = $clog2(FRAME_END + 1);

  seq_state_e        state;
  logic [CNT_W-1:0]  bit_i;
  logic              drain;
  logic              ovl_q;
  logic [CHAN_W-1:0] tag_q;
  logic              rise_stb, fall_stb;
  logic              slot, accept;
  logic [CNT_W-1:0]  last_of_frame;
  logic [CTRL_W-1:0] ctrl_word;

  assign last_of_frame = ovl_q ? CNT_W'(PER_OVL - 1) : CNT_W'(PER_SEQ - 1);
  assign slot      = (state == ST_RUN) && !drain && fall_stb && (bit_i == last_of_frame);
  assign cmd_ready = (state == ST_IDLE) || slot;
  assign accept    = cmd_valid && cmd_ready;
  assign ctrl_word = {1'b1, cmd_chan, cmd_opt};

  ahs_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst(rst), .run(state == ST_RUN),
    .sclk(sclk), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  ahs_tx_shift #(.CTRL_W(CTRL_W)) u_tx (
    .clk(clk), .rst(rst), .load(accept), .load_word(ctrl_word),
    .shift(fall_stb), .mosi(mosi)
  );

  ahs_rx_capture #(.RES_W(RES_W), .TAG_W(CHAN_W)) u_rx (
    .clk(clk), .rst(rst), .sample(rise_stb),
    .first(bit_i == CNT_W'(RES_FIRST)), .miso(miso), .tag_in(tag_q),
    .res_valid(res_valid), .res_data(res_data), .res_tag(res_chan)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cs_n  <= 1'b1;
      bit_i <= '0;
      drain <= 1'b0;
      ovl_q <= 1'b0;
      tag_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            state <= ST_RUN;
            cs_n  <= 1'b0;
            bit_i <= '0;
            drain <= 1'b0;
            ovl_q <= cfg_ovl;
            tag_q <= cmd_chan;
          end
        end
        default: begin
          if (fall_stb) begin
            if (slot && cmd_valid) begin
              bit_i <= '0;
              tag_q <= cmd_chan;
            end else if (slot) begin
              drain <= 1'b1;
              bit_i <= bit_i + 1'b1;
            end else if (bit_i == CNT_W'(FRAME_END - 1)) begin
              state <= ST_IDLE;
              cs_n  <= 1'b1;
              bit_i <= '0;
              drain <= 1'b0;
            end else begin
              bit_i <= bit_i + 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R1: the serial clock rests low while chip select is high
  a_r1_idle_low: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
  // R3: the first bit presented in a run is the start bit
  a_r3_start_bit: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> mosi);
  // R2: data to the converter holds across the high half of sclk
  a_r2_mosi_hold: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R9: padding clocks carry zeros
  a_r9_pad_zero: assert property (@(posedge clk) disable iff (rst)
    (drain && !cs_n) |-> !mosi);
  // R8: the frame counter never passes the end of a frame
  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> (bit_i < CNT_W'(FRAME_END)));
endmodule

// File: tb/tb_adc_host_seq.sv
`timescale 1ns/1ps
module tb_adc_host_seq;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_ovl = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_chan = '0;
  logic [3:0] cmd_opt = '0;
  logic cs_n, sclk, mosi;
  logic miso = 1'b0;
  logic res_valid;
  logic [11:0] res_data;
  logic [2:0] res_chan;

  adc_host_seq #(.HALF_DIV(HALF)) dut (
    .clk(clk), .rst(rst), .cfg_ovl(cfg_ovl), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_chan(cmd_chan), .cmd_opt(cmd_opt),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso),
    .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [2:0] q_chan [0:255];
  logic [3:0] q_opt  [0:255];
  int gidx = 0, ridx = 0, mconv = 0;
  int exp_per = 15;
  int rc = 0, next_start = 0, s_pos = 0, drv_start = -100;
  int rx_left = 0, starts_run = 0, results_run = 0;
  logic [7:0] rx_word = '0;
  logic [11:0] drv_word = '0;
  time last_rise = 0;

  function automatic logic [11:0] res_of(input int n, input logic [2:0] ch);
    res_of = 12'((n * 173 + int'(ch) * 611 + 5) ^ 12'h9A3);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  // converter model: reset per run
  always @(negedge cs_n) begin
    rc = 0; next_start = 0; drv_start = -100; rx_left = 0;
    starts_run = 0; results_run = 0; miso = 1'b0;
  end

  always @(posedge sclk) begin
    if (!cs_n) begin
      if (rc > 0)
        check(($time - last_rise) == 2 * HALF * 10, "R2 sclk period",
              $time - last_rise, 2 * HALF * 10);
      last_rise = $time;
      if (rx_left > 0) begin
        rx_word = {rx_word[6:0], mosi};
        rx_left--;
        if (rx_left == 0) begin
          check(rx_word == {1'b1, q_chan[mconv-1], q_opt[mconv-1]}, "R3 control word",
                rx_word, {1'b1, q_chan[mconv-1], q_opt[mconv-1]});
          drv_word  = res_of(mconv - 1, rx_word[6:4]);
          drv_start = s_pos;
        end
      end else if (mosi) begin
        check(rc == next_start, (exp_per == 15) ? "R4 start spacing" : "R5 start spacing",
              rc, next_start);
        s_pos = rc; rx_word = 8'd1; rx_left = 7;
        next_start = rc + exp_per;
        mconv++; starts_run++;
      end
      rc++;
    end
  end

  always @(negedge sclk) begin
    if (!cs_n) begin
      int d;
      d = (rc - 1) - drv_start;
      if (d >= 8 && d <= 19) miso = drv_word[19 - d];
      else miso = 1'b0;
    end
  end

  // result monitor, R7 and R10
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      check(res_data == res_of(ridx, q_chan[ridx]), "R7 result data",
            res_data, res_of(ridx, q_chan[ridx]));
      check(res_chan == q_chan[ridx], "R10 result order/channel", res_chan, q_chan[ridx]);
      ridx++; results_run++;
    end
  end

  task automatic run_seq(input int n, input bit ovl, input bit flip);
    int p;
    p = ovl ? 15 : 16;
    exp_per = p;
    cfg_ovl = ovl;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      q_chan[gidx] = 3'(gidx % 8);
      q_opt[gidx]  = 4'((gidx * 5 + 3) % 16);
      cmd_chan  = q_chan[gidx];
      cmd_opt   = q_opt[gidx];
      cmd_valid = 1'b1;
      while (!cmd_ready) @(negedge clk);
      @(posedge clk);
      gidx++;
      @(negedge clk);
      if (flip && i == 0) cfg_ovl = ~cfg_ovl; // R6: ignored mid-run
    end
    cmd_valid = 1'b0;
    while (!cs_n) @(negedge clk);
    check(rc == (n - 1) * p + 21, flip ? "R6 run length" : "R9 run length", rc, (n - 1) * p + 21);
    check(starts_run == n, "R8 conversions in one cs_n low", starts_run, n);
    check(results_run == n, "R10 result count", results_run, n);
    check(!sclk && !mosi && cmd_ready, "R1 idle between runs", {sclk, mosi, cmd_ready}, 3'b001);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cs_n == 1'b1, "R1 reset cs_n", cs_n, 1);
    check(sclk == 1'b0 && mosi == 1'b0, "R1 reset sclk/mosi", {sclk, mosi}, 0);
    check(res_valid == 1'b0, "R1 reset res_valid", res_valid, 0);
    check(cmd_ready == 1'b1, "R1 reset cmd_ready", cmd_ready, 1);
    for (int m = 0; m < 2; m++) begin
      run_seq(1, m == 0, 1'b0);
      run_seq(2, m == 0, 1'b0);
      run_seq(3, m == 0, 1'b0);
      run_seq(4, m == 0, 1'b0);
      run_seq(8, m == 0, 1'b0);
    end
    run_seq(5, 1'b1, 1'b1);
    run_seq(5, 1'b0, 1'b1);
    check(ridx == gidx, "R10 total results", ridx, gidx);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule